// File: doc/BRIEF.md
# Boundary-Scan Test Port with Pin Control

This block is a complete boundary-scan test port for a chip's pin ring. A five-wire serial test interface moves a sixteen-state controller through its capture, shift and update phases. The controller loads either a four-bit instruction register or the data register that the instruction picks. The data register is either a single pass-through cell or a boundary register of two cells per pin: one for the data level and one for the output enable.

The active instruction decides who controls the pins. In functional mode the core's levels and enables pass straight to the pads. The external-drive and clamp instructions put the update stage of the boundary register on the pads. The float instruction turns every driver off. Float and clamp also hold the core in reset through a request output, and both give the one-cell path for serial data, so other chips on a shared board chain can be tested with short scans.

Top module: `jtag_pinctl_tap`

## Requirements
- R1: While `trst_n` is low, and in the Test-Logic-Reset state, `sys_rst_req` is 0, `tdo_oe` is 0, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R2: In Capture-IR the instruction shift stage loads 0001. The bits leave on `tdo` least significant first, so the first four bits read while shifting an instruction are 1,0,0,0.
- R3: The code 1111 selects exactly one shift cell between `tdi` and `tdo`. That cell loads 0 in Capture-DR, so the first bit out is 0 and each later bit is the `tdi` bit from one shift earlier.
- R4: Any code other than 0000, 0001, 1001 and 1100 behaves as 1111: one-cell path, no reset request, pins passed through.
- R5: Code 0001 (sample/preload) captures `{core_oe, pin_in}` into the boundary register in Capture-DR. Bits 3:0 hold the pin levels, bits 7:4 the enables, and bit 0 leaves first. It shifts without changing the pads, which keep following the core.
- R6: In Update-DR with a boundary instruction active, the shift stage is copied to the update stage. Under code 0000 (external drive), `pad_out` = update bits 3:0, `pad_oe` = update bits 7:4, and `sys_rst_req` = 0.
- R7: Code 1001 (float) forces `pad_oe` to all zeros, raises `sys_rst_req` and gives the one-cell data path.
- R8: Code 1100 (clamp) drives `pad_out` and `pad_oe` from the update stage, raises `sys_rst_req` and gives the one-cell data path. Scans under clamp leave the pads unchanged.
- R9: A newly shifted instruction has no effect on the pads or on `sys_rst_req` until Update-IR.
- R10: Five clocks with `tms` high from any state reach Test-Logic-Reset and restore 1111, releasing reset and returning the pins to the core.
- R11: `tdo` changes on the falling `tck` edge, and `tdo_oe` is 1 only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Enable for the `tdo` driver |
| core_out | input | NPIN | Output levels from the core |
| core_oe | input | NPIN | Output enables from the core |
| pin_in | input | NPIN | Levels observed at the pads |
| pad_out | output | NPIN | Level sent to each pad driver |
| pad_oe | output | NPIN | Enable for each pad driver |
| sys_rst_req | output | 1 | Reset request to the core logic |

## Verification
An Update-IR edge can move the pad control and the reset request in the same cycle. Leaving clamp for float changes the enables from the update stage to all zeros while reset stays high. A forced return to Test-Logic-Reset then drops the reset request and gives the pins back to the core on one edge. The bench sets up both transitions: it preloads a pattern whose enables differ from the core's, then switches instructions. On the cycle after the edge it compares each pad field and the reset line with values worked out from the instruction codes. It also checks that the pads are unchanged while the new code is still only in the shift stage.

// File: rtl/tap_pkg.sv
package tap_pkg;
   typedef enum logic [3:0] {
      ST_TLR    = 4'd0,
      ST_RTI    = 4'd1,
      ST_SELDR  = 4'd2,
      ST_CAPDR  = 4'd3,
      ST_SHDR   = 4'd4,
      ST_EX1DR  = 4'd5,
      ST_PAUSDR = 4'd6,
      ST_EX2DR  = 4'd7,
      ST_UPDDR  = 4'd8,
      ST_SELIR  = 4'd9,
      ST_CAPIR  = 4'd10,
      ST_SHIR   = 4'd11,
      ST_EX1IR  = 4'd12,
      ST_PAUSIR = 4'd13,
      ST_EX2IR  = 4'd14,
      ST_UPDIR  = 4'd15
   } tap_state_e;

   typedef enum logic [2:0] {
      MD_PASS   = 3'd0,
      MD_DRIVE  = 3'd1,
      MD_SAMPLE = 3'd2,
      MD_FLOAT  = 3'd3,
      MD_CLAMP  = 3'd4
   } pin_mode_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);
   tap_state_e nxt;

   always_comb begin
      case (state)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SELDR  : ST_RTI;
         ST_SELDR:  nxt = tms ? ST_SELIR  : ST_CAPDR;
         ST_CAPDR:  nxt = tms ? ST_EX1DR  : ST_SHDR;
         ST_SHDR:   nxt = tms ? ST_EX1DR  : ST_SHDR;
         ST_EX1DR:  nxt = tms ? ST_UPDDR  : ST_PAUSDR;
         ST_PAUSDR: nxt = tms ? ST_EX2DR  : ST_PAUSDR;
         ST_EX2DR:  nxt = tms ? ST_UPDDR  : ST_SHDR;
         ST_UPDDR:  nxt = tms ? ST_SELDR  : ST_RTI;
         ST_SELIR:  nxt = tms ? ST_TLR    : ST_CAPIR;
         ST_CAPIR:  nxt = tms ? ST_EX1IR  : ST_SHIR;
         ST_SHIR:   nxt = tms ? ST_EX1IR  : ST_SHIR;
         ST_EX1IR:  nxt = tms ? ST_UPDIR  : ST_PAUSIR;
         ST_PAUSIR: nxt = tms ? ST_EX2IR  : ST_PAUSIR;
         ST_EX2IR:  nxt = tms ? ST_UPDIR  : ST_SHIR;
         default:   nxt = tms ? ST_SELDR  : ST_RTI;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= nxt;
   end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int          IR_W        = 4,
   parameter logic [IR_W-1:0] CODE_DRIVE  = 4'b0000,
   parameter logic [IR_W-1:0] CODE_SAMPLE = 4'b0001,
   parameter logic [IR_W-1:0] CODE_FLOAT  = 4'b1001,
   parameter logic [IR_W-1:0] CODE_CLAMP  = 4'b1100,
   parameter logic [IR_W-1:0] CODE_BYP    = 4'b1111
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic            ir_so,
   output logic [IR_W-1:0] ir_active,
   output pin_mode_e       mode
);
   localparam logic [IR_W-1:0] CAPTURE_VAL = {{(IR_W-2){1'b0}}, 2'b01};

   logic [IR_W-1:0] sr_q;
   logic [IR_W-1:0] eff;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr_q      <= CAPTURE_VAL;
         ir_active <= CODE_BYP;
      end else begin
         case (state)
            ST_CAPIR: sr_q <= CAPTURE_VAL;
            ST_SHIR:  sr_q <= {tdi, sr_q[IR_W-1:1]};
            default:  sr_q <= sr_q;
         endcase
         if (state == ST_TLR)        ir_active <= CODE_BYP;
         else if (state == ST_UPDIR) ir_active <= sr_q;
      end
   end

   assign ir_so = sr_q[0];

   always_comb begin
      eff = (state == ST_TLR) ? CODE_BYP : ir_active;
      if (eff == CODE_DRIVE)       mode = MD_DRIVE;
      else if (eff == CODE_SAMPLE) mode = MD_SAMPLE;
      else if (eff == CODE_FLOAT)  mode = MD_FLOAT;
      else if (eff == CODE_CLAMP)  mode = MD_CLAMP;
      else                         mode = MD_PASS;
   end
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
   import tap_pkg::*;
#(
   parameter int NPIN = 4,
   localparam int LEN = 2 * NPIN
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  pin_mode_e       mode,
   input  logic            tdi,
   input  logic [NPIN-1:0] core_out,
   input  logic [NPIN-1:0] core_oe,
   input  logic [NPIN-1:0] pin_in,
   output logic            bsr_so,
   output logic [LEN-1:0]  upd_q,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe
);
   logic [LEN-1:0] sr_q;
   logic           sel;
   logic           use_upd;
   logic           all_off;

   assign sel     = (mode == MD_DRIVE) || (mode == MD_SAMPLE);
   assign use_upd = (mode == MD_DRIVE) || (mode == MD_CLAMP);
   assign all_off = (mode == MD_FLOAT);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr_q  <= '0;
         upd_q <= '0;
      end else if (sel) begin
         case (state)
            ST_CAPDR: sr_q  <= {core_oe, pin_in};
            ST_SHDR:  sr_q  <= {tdi, sr_q[LEN-1:1]};
            ST_UPDDR: upd_q <= sr_q;
            default:  ;
         endcase
      end
   end

   assign bsr_so = sr_q[0];

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign pad_out[i] = use_upd ? upd_q[i] : core_out[i];
      assign pad_oe[i]  = all_off ? 1'b0 :
                          (use_upd ? upd_q[NPIN+i] : core_oe[i]);
   end
endmodule

// File: rtl/jtag_pinctl_tap.sv
module jtag_pinctl_tap
   import tap_pkg::*;
#(
   parameter int NPIN = 4,
   parameter int IR_W = 4,
   parameter logic [IR_W-1:0] CODE_DRIVE  = 4'b0000,
   parameter logic [IR_W-1:0] CODE_SAMPLE = 4'b0001,
   parameter logic [IR_W-1:0] CODE_FLOAT  = 4'b1001,
   parameter logic [IR_W-1:0] CODE_CLAMP  = 4'b1100,
   parameter logic [IR_W-1:0] CODE_BYP    = 4'b1111
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tms,
   input  logic            tdi,
   output logic            tdo,
   output logic            tdo_oe,
   input  logic [NPIN-1:0] core_out,
   input  logic [NPIN-1:0] core_oe,
   input  logic [NPIN-1:0] pin_in,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe,
   output logic            sys_rst_req
);
   localparam int LEN = 2 * NPIN;

   if (NPIN < 1) begin : g_bad_npin
      $error("NPIN must be at least 1");
   end
   if (IR_W < 2) begin : g_bad_irw
      $error("IR_W must be at least 2");
   end

   tap_state_e      fsm_state;
   pin_mode_e       mode;
   logic [IR_W-1:0] ir_q;
   logic [LEN-1:0]  upd_q;
   logic            ir_so;
   logic            bsr_so;
   logic            byp_q;
   logic            dr_so;

   tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (fsm_state)
   );

   tap_ir #(
      .IR_W        (IR_W),
      .CODE_DRIVE  (CODE_DRIVE),
      .CODE_SAMPLE (CODE_SAMPLE),
      .CODE_FLOAT  (CODE_FLOAT),
      .CODE_CLAMP  (CODE_CLAMP),
      .CODE_BYP    (CODE_BYP)
   ) u_ir (
      .tck       (tck),
      .trst_n    (trst_n),
      .state     (fsm_state),
      .tdi       (tdi),
      .ir_so     (ir_so),
      .ir_active (ir_q),
      .mode      (mode)
   );

   tap_bsr #(.NPIN(NPIN)) u_bsr (
      .tck      (tck),
      .trst_n   (trst_n),
      .state    (fsm_state),
      .mode     (mode),
      .tdi      (tdi),
      .core_out (core_out),
      .core_oe  (core_oe),
      .pin_in   (pin_in),
      .bsr_so   (bsr_so),
      .upd_q    (upd_q),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   // single pass-through cell, cleared on capture
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  byp_q <= 1'b0;
      else if (fsm_state == ST_CAPDR) byp_q <= 1'b0;
      else if (fsm_state == ST_SHDR)  byp_q <= tdi;
   end

   assign dr_so = ((mode == MD_DRIVE) || (mode == MD_SAMPLE)) ? bsr_so : byp_q;

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= (fsm_state == ST_SHIR) ? ir_so : dr_so;
         tdo_oe <= (fsm_state == ST_SHIR) || (fsm_state == ST_SHDR);
      end
   end

   assign sys_rst_req = (mode == MD_FLOAT) || (mode == MD_CLAMP);
endmodule

// File: rtl/tap_pinctl_chk.sv
module tap_pinctl_chk
   import tap_pkg::*;
#(
   parameter int NPIN = 4,
   parameter int IR_W = 4
) (
   input logic              tck,
   input logic              trst_n,
   input tap_state_e        state,
   input pin_mode_e         mode,
   input logic [IR_W-1:0]   ir_q,
   input logic              byp_q,
   input logic [2*NPIN-1:0] upd_q,
   input logic [NPIN-1:0]   core_out,
   input logic [NPIN-1:0]   core_oe,
   input logic [NPIN-1:0]   pad_out,
   input logic [NPIN-1:0]   pad_oe,
   input logic              tdo_oe,
   input logic              sys_rst_req
);
   always_comb begin
      if (!trst_n) begin
         p_trst_release_r1: assert (!sys_rst_req && pad_oe == core_oe && pad_out == core_out);
      end
   end

   p_tlr_pass_r10: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR) |-> (!sys_rst_req && pad_out == core_out && pad_oe == core_oe));

   p_bypass_zero_r3: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAPDR) |=> (byp_q == 1'b0));

   p_float_off_r7: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == MD_FLOAT) |-> (pad_oe == '0 && sys_rst_req));

   p_clamp_pins_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == MD_CLAMP) |-> (pad_out == upd_q[NPIN-1:0] && pad_oe == upd_q[2*NPIN-1:NPIN] && sys_rst_req));

   p_ir_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
      !(state inside {ST_UPDIR, ST_TLR}) |=> $stable(ir_q));

   p_tdo_en_r11: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (state == ST_SHIR || state == ST_SHDR));
endmodule

bind jtag_pinctl_tap tap_pinctl_chk #(.NPIN(NPIN), .IR_W(IR_W)) u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .state       (fsm_state),
   .mode        (mode),
   .ir_q        (ir_q),
   .byp_q       (byp_q),
   .upd_q       (upd_q),
   .core_out    (core_out),
   .core_oe     (core_oe),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .tdo_oe      (tdo_oe),
   .sys_rst_req (sys_rst_req)
);

// File: tb/jtag_pinctl_tap_tb.sv
module jtag_pinctl_tap_tb;
   localparam int NPIN = 4;

   logic            tck = 1'b0;
   logic            trst_n = 1'b0;
   logic            tms = 1'b1;
   logic            tdi = 1'b0;
   logic            tdo;
   logic            tdo_oe;
   logic [NPIN-1:0] core_out = 4'h3;
   logic [NPIN-1:0] core_oe  = 4'hC;
   logic [NPIN-1:0] pin_in   = 4'h9;
   logic [NPIN-1:0] pad_out;
   logic [NPIN-1:0] pad_oe;
   logic            sys_rst_req;

   int checks = 0;
   int fails  = 0;

   always #5 tck = ~tck;

   jtag_pinctl_tap #(.NPIN(NPIN)) u_dut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
      .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .sys_rst_req(sys_rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive, take one rising edge, settle past the following falling edge
   task automatic tick(input logic m, input logic d);
      tms = m; tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
   endtask

   task automatic pins(input string req, input logic [3:0] o, input logic [3:0] e, input logic r);
      chk({req, " pad_out"}, 32'(pad_out), 32'(o));
      chk({req, " pad_oe"}, 32'(pad_oe), 32'(e));
      chk({req, " sys_rst_req"}, 32'(sys_rst_req), 32'(r));
   endtask

   task automatic ir_shift(input logic [3:0] code, output logic [3:0] so);
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      chk("R11 tdo_oe in Shift-IR", 32'(tdo_oe), 32'd1);
      for (int i = 0; i < 4; i++) begin
         so[i] = tdo;
         tick(i == 3, code[i]);
      end
   endtask

   task automatic ir_finish();
      tick(1, 0); tick(0, 0);
   endtask

   task automatic load_ir(input logic [3:0] code);
      logic [3:0] so;
      ir_shift(code, so);
      chk("R2 captured instruction bits", 32'(so), 32'h1);
      ir_finish();
   endtask

   task automatic scan_dr(input logic [7:0] din, output logic [7:0] dout);
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < 8; i++) begin
         dout[i] = tdo;
         tick(i == 7, din[i]);
      end
      tick(1, 0); tick(0, 0);
   endtask

   task automatic t_reset();
      #1;
      pins("R1 during trst", 4'h3, 4'hC, 1'b0);
      chk("R1 tdo_oe during trst", 32'(tdo_oe), 32'd0);
      @(negedge tck); trst_n = 1'b1;
      tick(1, 0);
      pins("R1 in TLR", 4'h3, 4'hC, 1'b0);
      tick(0, 0);
      chk("R11 tdo_oe in idle", 32'(tdo_oe), 32'd0);
   endtask

   task automatic t_bypass(input logic [3:0] code, input string req);
      logic [7:0] dout;
      load_ir(code);
      pins(req, 4'h3, 4'hC, 1'b0);
      scan_dr(8'b1011_0110, dout);
      chk({req, " one-cell path, first bit 0"}, 32'(dout), 32'({7'b011_0110, 1'b0}));
   endtask

   task automatic t_sample();
      logic [7:0] dout;
      load_ir(4'b0001);
      scan_dr(8'hA5, dout);
      chk("R5 capture {core_oe,pin_in}", 32'(dout), 32'hC9);
      pins("R5 pads untouched", 4'h3, 4'hC, 1'b0);
   endtask

   task automatic t_extest();
      load_ir(4'b0000);
      pins("R6 drive update stage", 4'h5, 4'hA, 1'b0);
   endtask

   task automatic t_clamp();
      logic [7:0] dout;
      load_ir(4'b1100);
      pins("R8 clamp", 4'h5, 4'hA, 1'b1);
      scan_dr(8'hFF, dout);
      chk("R8 one-cell path under clamp", 32'(dout), 32'hFE);
      pins("R8 pads held after scan", 4'h5, 4'hA, 1'b1);
   endtask

   task automatic t_float();
      logic [3:0] so;
      logic [7:0] dout;
      ir_shift(4'b1001, so);
      pins("R9 before Update-IR", 4'h5, 4'hA, 1'b1);
      ir_finish();
      chk("R7 float pad_oe", 32'(pad_oe), 32'h0);
      chk("R7 float sys_rst_req", 32'(sys_rst_req), 32'd1);
      scan_dr(8'h01, dout);
      chk("R7 one-cell path under float", 32'(dout), 32'h02);
   endtask

   task automatic t_tms_reset();
      for (int i = 0; i < 5; i++) tick(1, 0);
      pins("R10 five tms-high clocks", 4'h3, 4'hC, 1'b0);
      tick(0, 0);
      pins("R10 bypass after reset", 4'h3, 4'hC, 1'b0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge tck);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_bypass(4'b1111, "R3");
      t_bypass(4'b0101, "R4");
      t_sample();
      t_extest();
      t_clamp();
      t_float();
      t_tms_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule